// File: doc/BRIEF.md
# Coprocessor-0 Timer, Replacement Index and Interrupt Unit

This block is the timekeeping and interrupt-decision part of a processor's system-control coprocessor. Each time the core signals a tick, it advances a 32-bit free-running counter and a 6-bit down-counting index. The index selects which translation-buffer entry to replace next. It never enters the range of entries that software has pinned below a programmable floor.

When the advanced counter reaches a software-programmed compare value, the block latches a timer interrupt on the top pending bit. That bit stays set until software writes the compare value again. External interrupt lines are registered into the lower pending bits every cycle.

The block holds the processor status word. From that word it derives three things:
- whether an interrupt must be requested;
- the current privilege level;
- whether a coprocessor-0 access attempted in the current cycle must be refused as unusable.

The pending bits and the coprocessor-enable code are presented in a cause-register view for the surrounding exception logic.

Top module: `cp0_timer_irq_unit`

## Requirements
- R1: After synchronous reset, `count_o` is 0, `random_o` is 63, the replacement floor is 0, `cause_o` is 0 and `irq_req_o` is 0. The status word resets to 0x0040_0000: boot-vector bit 22 is set and all other bits are clear, so `priv_o` reads kernel.
- R2: On a clock edge with `tick_i` high, `random_o` becomes 63 if it equals the replacement floor, and otherwise decreases by one. Without `tick_i` it holds. A floor write (`wired_we_i`) takes effect from the following edge.
- R3: On a clock edge with `tick_i` high, `count_o` increases by one, wrapping modulo 2^32. Without `tick_i` it holds.
- R4: When a tick makes the incremented count equal the compare value, pending bit 7 (`cause_o[15]`) is set at that edge. It then stays set until a compare write.
- R5: A compare write (`cmp_we_i`) clears pending bit 7 at that edge. The clear wins over a timer match on the same edge. A match is judged against the compare value held before the write.
- R6: Pending bits 6..0 (`cause_o[14:8]`) take the value of `ext_irq_i` at every edge, so they lag the input by one cycle.
- R7: `irq_req_o` is 1 only when all four of these status bits hold:
  - IE (bit 0) is 1;
  - EXL (bit 1) is 0;
  - ERL (bit 2) is 0;
  - the pending byte ANDed with IM (status bits 15:8) is nonzero.
- R8: `priv_o` gives the privilege level, encoded 00 kernel, 01 supervisor, 10 user. It is kernel whenever EXL or ERL is set. Otherwise the mode field (status bits 4:3) decides: 00 gives kernel, 01 supervisor, and 10 or 11 user.
- R9: `cpu_fault_o` is 1 in the same cycle as `cp0_acc_i` when the level is not kernel and coprocessor-enable bit 0 (status bit 28) is clear. The coprocessor-enable code in `cause_o[29:28]` reads 00.
- R10: A status write (`stat_we_i`) loads all 32 bits at that edge. Its effect on `priv_o`, `irq_req_o` and `cpu_fault_o` is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Advance count and replacement index |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 32 | Compare write data |
| wired_we_i | input | 1 | Replacement floor write strobe |
| wired_wdata_i | input | 6 | Replacement floor write data |
| stat_we_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 32 | Status write data |
| ext_irq_i | input | 7 | External interrupt lines |
| cp0_acc_i | input | 1 | A coprocessor-0 access is attempted this cycle |
| count_o | output | 32 | Free-running counter |
| random_o | output | 6 | Replacement index |
| cause_o | output | 32 | Cause view: CE at 29:28, pending byte at 15:8, others 0 |
| irq_req_o | output | 1 | Interrupt exception request |
| priv_o | output | 2 | Privilege level |
| cpu_fault_o | output | 1 | Coprocessor-unusable fault |

## Verification
The index is walked across a floor write and through the reload. This separates a reload at the floor from a natural wrap at zero. Idle cycles then show that the counters do not move without a tick.

The timer is approached one tick short of the compare value and then hit, which exposes off-by-one matches. A compare write issued on the very edge of a match shows that the clear takes priority.

The interrupt request is tried four ways:
- with each single gating bit defeated in turn;
- with a mask that misses the pending line;
- from an external line;
- from the timer line.

All four mode-field codes are combined with EXL and ERL. The coprocessor fault is tried across privilege levels and enable-bit values, with and without an access.

// File: rtl/cp0t_pkg.sv
package cp0t_pkg;

    localparam int IP_W      = 8;
    localparam int EXT_IRQ_W = IP_W - 1;
    localparam int TIMER_BIT = IP_W - 1;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_USER   = 2'b10
    } priv_e;

    typedef struct packed {
        logic [3:0] cu;
        logic [4:0] rsv_hi;
        logic       bev;
        logic [5:0] rsv_mid;
        logic [7:0] im;
        logic       kx;
        logic       sx;
        logic       ux;
        logic [1:0] ksu;
        logic       erl;
        logic       exl;
        logic       ie;
    } status_t;

    localparam logic [31:0] STATUS_RST = 32'h0040_0000;

    function automatic priv_e level_of(input status_t s);
        if (s.exl || s.erl) return PRIV_KERNEL;
        case (s.ksu)
            2'b00:   return PRIV_KERNEL;
            2'b01:   return PRIV_SUPER;
            default: return PRIV_USER;
        endcase
    endfunction

    function automatic logic irq_wanted(input status_t s, input logic [IP_W-1:0] pend);
        return !s.exl && !s.erl && s.ie && ((pend & s.im) != '0);
    endfunction

endpackage

// File: rtl/cp0t_random_ctr.sv
module cp0t_random_ctr #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wired_we_i,
    input  logic [IDX_W-1:0] wired_wdata_i,
    output logic [IDX_W-1:0] random_o,
    output logic [IDX_W-1:0] wired_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] random_q;
    logic [IDX_W-1:0] wired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            random_q <= IDX_MAX;
            wired_q  <= '0;
        end else begin
            if (tick_i) begin
                random_q <= (random_q == wired_q) ? IDX_MAX : random_q - IDX_W'(1);
            end
            if (wired_we_i) begin
                wired_q <= wired_wdata_i;
            end
        end
    end

    assign random_o = random_q;
    assign wired_o  = wired_q;
endmodule

// File: rtl/cp0t_count_cmp.sv
module cp0t_count_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] compare_o,
    output logic             timer_hit_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] compare_q;
    logic [CNT_W-1:0] count_nxt;

    assign count_nxt = count_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            compare_q <= '0;
        end else begin
            if (tick_i)   count_q   <= count_nxt;
            if (cmp_we_i) compare_q <= cmp_wdata_i;
        end
    end

    assign timer_hit_o = tick_i && (count_nxt == compare_q);
    assign count_o     = count_q;
    assign compare_o   = compare_q;
endmodule

// File: rtl/cp0t_pending.sv
module cp0t_pending
    import cp0t_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 timer_hit_i,
    input  logic                 timer_clr_i,
    input  logic [EXT_IRQ_W-1:0] ext_irq_i,
    input  status_t              status_i,
    output logic [IP_W-1:0]      ip_o,
    output logic                 irq_req_o
);
    logic [EXT_IRQ_W-1:0] ext_q;
    logic                 timer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q   <= '0;
            timer_q <= 1'b0;
        end else begin
            ext_q <= ext_irq_i;
            if (timer_clr_i)      timer_q <= 1'b0;
            else if (timer_hit_i) timer_q <= 1'b1;
        end
    end

    assign ip_o      = {timer_q, ext_q};
    assign irq_req_o = irq_wanted(status_i, ip_o);
endmodule

// File: rtl/cp0t_status_priv.sv
module cp0t_status_priv
    import cp0t_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stat_we_i,
    input  logic [31:0] stat_wdata_i,
    input  logic        cp0_acc_i,
    output status_t     status_o,
    output priv_e       priv_o,
    output logic        cpu_fault_o,
    output logic [1:0]  ce_o
);
    status_t status_q;

    always_ff @(posedge clk) begin
        if (rst)            status_q <= status_t'(STATUS_RST);
        else if (stat_we_i) status_q <= status_t'(stat_wdata_i);
    end

    assign priv_o      = level_of(status_q);
    assign cpu_fault_o = cp0_acc_i && (priv_o != PRIV_KERNEL) && !status_q.cu[0];
    assign ce_o        = 2'b00;
    assign status_o    = status_q;
endmodule

// File: rtl/cp0_timer_irq_unit.sv
module cp0_timer_irq_unit
    import cp0t_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 cmp_we_i,
    input  logic [CNT_W-1:0]     cmp_wdata_i,
    input  logic                 wired_we_i,
    input  logic [IDX_W-1:0]     wired_wdata_i,
    input  logic                 stat_we_i,
    input  logic [31:0]          stat_wdata_i,
    input  logic [EXT_IRQ_W-1:0] ext_irq_i,
    input  logic                 cp0_acc_i,
    output logic [CNT_W-1:0]     count_o,
    output logic [IDX_W-1:0]     random_o,
    output logic [31:0]          cause_o,
    output logic                 irq_req_o,
    output logic [1:0]           priv_o,
    output logic                 cpu_fault_o
);
    logic [IDX_W-1:0] wired_q;
    logic [CNT_W-1:0] compare_q;
    logic             timer_hit;
    status_t          status_q;
    priv_e            level;
    logic [IP_W-1:0]  ip_q;
    logic [1:0]       ce_code;

    cp0t_random_ctr #(.IDX_W(IDX_W)) u_rnd (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick_i),
        .wired_we_i    (wired_we_i),
        .wired_wdata_i (wired_wdata_i),
        .random_o      (random_o),
        .wired_o       (wired_q)
    );

    cp0t_count_cmp #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .cmp_we_i    (cmp_we_i),
        .cmp_wdata_i (cmp_wdata_i),
        .count_o     (count_o),
        .compare_o   (compare_q),
        .timer_hit_o (timer_hit)
    );

    cp0t_status_priv u_stat (
        .clk          (clk),
        .rst          (rst),
        .stat_we_i    (stat_we_i),
        .stat_wdata_i (stat_wdata_i),
        .cp0_acc_i    (cp0_acc_i),
        .status_o     (status_q),
        .priv_o       (level),
        .cpu_fault_o  (cpu_fault_o),
        .ce_o         (ce_code)
    );

    cp0t_pending u_pend (
        .clk         (clk),
        .rst         (rst),
        .timer_hit_i (timer_hit),
        .timer_clr_i (cmp_we_i),
        .ext_irq_i   (ext_irq_i),
        .status_i    (status_q),
        .ip_o        (ip_q),
        .irq_req_o   (irq_req_o)
    );

    assign priv_o  = level;
    assign cause_o = {2'b00, ce_code, 12'h000, ip_q, 8'h00};
endmodule

// File: rtl/cp0t_checker.sv
module cp0t_checker
    import cp0t_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int IDX_W = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_i,
    input logic                 cmp_we_i,
    input logic [EXT_IRQ_W-1:0] ext_irq_i,
    input logic [CNT_W-1:0]     count_o,
    input logic [IDX_W-1:0]     random_o,
    input logic [31:0]          cause_o,
    input logic                 irq_req_o,
    input logic [1:0]           priv_o,
    input logic                 cpu_fault_o,
    input logic [IDX_W-1:0]     wired_q,
    input logic [CNT_W-1:0]     compare_q,
    input status_t              status_q
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    p_reload_at_floor_r2: assert property (@(posedge clk) disable iff (rst)
        tick_i && (random_o == wired_q) |=> random_o == IDX_MAX);

    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        tick_i && (random_o != wired_q) |=> random_o == $past(random_o) - IDX_W'(1));

    p_index_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(random_o));

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> count_o == $past(count_o) + CNT_W'(1));

    p_count_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o));

    p_timer_set_r4: assert property (@(posedge clk) disable iff (rst)
        tick_i && !cmp_we_i && (count_o + CNT_W'(1) == compare_q) |=> cause_o[15]);

    p_timer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cause_o[15] && !cmp_we_i |=> cause_o[15]);

    p_timer_clear_r5: assert property (@(posedge clk) disable iff (rst)
        cmp_we_i |=> !cause_o[15]);

    p_ext_sample_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cause_o[14:8] == $past(ext_irq_i));

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ((cause_o[15:8] & status_q.im) == 8'h00) |-> !irq_req_o);

    p_exc_kernel_r8: assert property (@(posedge clk) disable iff (rst)
        (status_q.exl || status_q.erl) |-> priv_o == PRIV_KERNEL);

    p_fault_level_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_fault_o |-> (priv_o != PRIV_KERNEL) && (cause_o[29:28] == 2'b00));
endmodule

bind cp0_timer_irq_unit cp0t_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .cmp_we_i    (cmp_we_i),
    .ext_irq_i   (ext_irq_i),
    .count_o     (count_o),
    .random_o    (random_o),
    .cause_o     (cause_o),
    .irq_req_o   (irq_req_o),
    .priv_o      (priv_o),
    .cpu_fault_o (cpu_fault_o),
    .wired_q     (wired_q),
    .compare_q   (compare_q),
    .status_q    (status_q)
);

// File: tb/cp0_timer_irq_unit_test.sv
module cp0_timer_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        cmp_we_i = 1'b0;
    logic [31:0] cmp_wdata_i = '0;
    logic        wired_we_i = 1'b0;
    logic [5:0]  wired_wdata_i = '0;
    logic        stat_we_i = 1'b0;
    logic [31:0] stat_wdata_i = '0;
    logic [6:0]  ext_irq_i = '0;
    logic        cp0_acc_i = 1'b0;
    logic [31:0] count_o;
    logic [5:0]  random_o;
    logic [31:0] cause_o;
    logic        irq_req_o;
    logic [1:0]  priv_o;
    logic        cpu_fault_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cp0_timer_irq_unit uut (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
        .wired_we_i(wired_we_i), .wired_wdata_i(wired_wdata_i),
        .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i),
        .ext_irq_i(ext_irq_i), .cp0_acc_i(cp0_acc_i),
        .count_o(count_o), .random_o(random_o), .cause_o(cause_o),
        .irq_req_o(irq_req_o), .priv_o(priv_o), .cpu_fault_o(cpu_fault_o)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        cyc(n);
        tick_i = 1'b0;
    endtask

    task automatic wr_status(input logic [31:0] v);
        stat_we_i = 1'b1;
        stat_wdata_i = v;
        cyc();
        stat_we_i = 1'b0;
    endtask

    task automatic wr_compare(input logic [31:0] v);
        cmp_we_i = 1'b1;
        cmp_wdata_i = v;
        cyc();
        cmp_we_i = 1'b0;
    endtask

    task automatic wr_wired(input logic [5:0] v);
        wired_we_i = 1'b1;
        wired_wdata_i = v;
        cyc();
        wired_we_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 count", count_o, 0);
        chk("R1 random", 32'(random_o), 63);
        chk("R1 cause", cause_o, 0);
        chk("R1 irq", 32'(irq_req_o), 0);
        chk("R1 priv", 32'(priv_o), 0);
        // The floor is 0 after reset, so 63 ticks walk the index down to 0.
        // One more tick reloads at the floor.
        ticks(63);
        chk("R1 floor zero", 32'(random_o), 0);
        ticks(1);
        chk("R1 reload at floor 0", 32'(random_o), 63);
    endtask

    task automatic t_random;
        ticks(5);
        chk("R2 step", 32'(random_o), 58);
        cyc(3);
        chk("R2 idle hold", 32'(random_o), 58);
        chk("R3 idle hold", count_o, 69);
        wr_wired(6'd55);
        ticks(3);
        chk("R2 reach floor", 32'(random_o), 55);
        ticks(1);
        chk("R2 reload at floor", 32'(random_o), 63);
        ticks(1);
        chk("R2 after reload", 32'(random_o), 62);
        wr_wired(6'd0);
        chk("R3 count", count_o, 74);
    endtask

    task automatic t_timer;
        wr_compare(32'd77);
        ticks(2);
        chk("R4 one short", 32'(cause_o[15]), 0);
        ticks(1);
        chk("R4 match count", count_o, 77);
        chk("R4 match sets", 32'(cause_o[15]), 1);
        ticks(2);
        chk("R4 sticky", 32'(cause_o[15]), 1);
        wr_compare(32'd81);
        chk("R5 write clears", 32'(cause_o[15]), 0);
        ticks(1);
        // The next tick matches compare 81, and a compare write lands on the same edge.
        tick_i = 1'b1;
        cmp_we_i = 1'b1;
        cmp_wdata_i = 32'd500;
        cyc();
        tick_i = 1'b0;
        cmp_we_i = 1'b0;
        chk("R5 clear wins", 32'(cause_o[15]), 0);
        chk("R5 count", count_o, 81);
    endtask

    task automatic t_ext;
        ext_irq_i = 7'h05;
        chk("R6 lag", 32'(cause_o[14:8]), 0);
        cyc();
        chk("R6 sample", 32'(cause_o[14:8]), 32'h05);
        ext_irq_i = 7'h40;
        cyc();
        chk("R6 sample2", 32'(cause_o[14:8]), 32'h40);
        ext_irq_i = 7'h00;
        cyc();
        chk("R6 drop", 32'(cause_o[14:8]), 0);
    endtask

    task automatic t_irq;
        wr_status(32'h0000_0101);
        ext_irq_i = 7'h01;
        cyc();
        chk("R7 request", 32'(irq_req_o), 1);
        wr_status(32'h0000_0103);
        chk("R7 EXL blocks", 32'(irq_req_o), 0);
        wr_status(32'h0000_0105);
        chk("R7 ERL blocks", 32'(irq_req_o), 0);
        wr_status(32'h0000_0100);
        chk("R7 IE off", 32'(irq_req_o), 0);
        wr_status(32'h0000_0201);
        chk("R7 mask miss", 32'(irq_req_o), 0);
        ext_irq_i = 7'h00;
        wr_status(32'h0000_8001);
        wr_compare(32'd83);
        ticks(2);
        chk("R7 timer request", 32'(irq_req_o), 1);
        wr_compare(32'd0);
        chk("R7 timer cleared", 32'(irq_req_o), 0);
    endtask

    task automatic t_priv;
        wr_status(32'h0000_0000);
        chk("R8 ksu00", 32'(priv_o), 0);
        wr_status(32'h0000_0008);
        chk("R8 ksu01", 32'(priv_o), 1);
        wr_status(32'h0000_0010);
        chk("R8 ksu10", 32'(priv_o), 2);
        wr_status(32'h0000_0018);
        chk("R8 ksu11", 32'(priv_o), 2);
        wr_status(32'h0000_0012);
        chk("R8 EXL kernel", 32'(priv_o), 0);
        wr_status(32'h0000_001C);
        chk("R8 ERL kernel", 32'(priv_o), 0);
    endtask

    task automatic t_cu;
        wr_status(32'h0000_0010);
        chk("R10 status load", 32'(priv_o), 2);
        chk("R9 no access", 32'(cpu_fault_o), 0);
        cp0_acc_i = 1'b1;
        #1;
        chk("R9 user fault", 32'(cpu_fault_o), 1);
        chk("R9 CE code", 32'(cause_o[29:28]), 0);
        wr_status(32'h1000_0010);
        chk("R9 cu0 permits", 32'(cpu_fault_o), 0);
        wr_status(32'h0000_0008);
        chk("R9 super fault", 32'(cpu_fault_o), 1);
        wr_status(32'h0000_0000);
        chk("R9 kernel ok", 32'(cpu_fault_o), 0);
        cp0_acc_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc();
        t_reset();
        t_random();
        t_timer();
        t_ext();
        t_irq();
        t_priv();
        t_cu();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule